// File: doc/BRIEF.md
# Timed and Burst DMA Sequencer

This block moves bytes for a single DMA channel. Each byte is fetched with one read cycle from the source and placed with one write cycle to the destination. Both cycles run on a bus shared with the CPU, and the block gains access to that bus through a request/grant handshake. Each side of the transfer is either memory or I/O. The start addresses, the byte count, the pacing interval and a watch address come from registers outside the block. A control byte selects the mode, the kind of each side, and which side the watch address is compared against.

There are three active modes:

- **Burst:** bytes move back to back while the CPU is held.
- **Timed, one-shot:** one byte moves each time a prescaler interval elapses. The bus is released between bytes, so the CPU keeps running, only slower.
- **Timed, repeating:** like the one-shot timed mode, but it reloads its programmed values when it finishes and starts over by itself.

The interval is counted on a fast tick when both sides are memory, and on a slow tick when either side is I/O. Whenever the watched access hits the watch address, a one-cycle flag is raised. The block raises no interrupt.

Top module: `dma_seq`

## Requirements
- R1: For each byte, a read cycle on the source is followed in the next clock by a write cycle on the destination. The write drives the byte captured during that read.
- R2: Control bit 3 set makes the source I/O, so reads use `io_rd_o`; clear makes it memory, using `mem_rd_o`. Control bit 2 does the same for the destination, selecting `io_wr_o` or `mem_wr_o`. At most one strobe is high in any cycle.
- R3: A memory-side address starts at its programmed value and advances by one after every byte. An I/O-side address keeps its programmed value for the whole transfer.
- R4: Mode code 01 (control bits 1..0) is burst. `cpu_hold_o` and `bus_req_o` stay high from the cycle after start until completion. While grant is held, each byte takes three cycles: request, read, write.
- R5: The length input is a byte count; the value 0 means 65536 bytes.
- R6: Mode codes 10 and 11 are timed. Each byte waits for one prescaler expiry, which comes every `presc_i` ticks (0 counts as 65536). The bus is requested only for that byte's read/write pair and is dropped between bytes.
- R7: The prescaler counts `tick_fast_i` when both sides are memory, and `tick_slow_i` when either side is I/O.
- R8: After the last byte, modes 01 and 10 return to idle. Mode 11 reloads the programmed addresses and count and continues without any new control write.
- R9: A transfer starts only when the mode field changes from 00 to a non-zero code. Mode 00 ends an active transfer, with `busy_o` low in the next cycle. A later start begins again from the programmed addresses.
- R10: Control bit 4 clear compares the watch address with each read address; set compares it with each write address. A match gives a one-cycle `probe_hit_o` in the cycle after that access.
- R11: After reset, `busy_o`, `bus_req_o`, `cpu_hold_o`, `probe_hit_o` and all strobes are low. `busy_o` is high from the cycle after start until completion or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 8 | Control byte: bits 1..0 mode, bit 2 destination is I/O, bit 3 source is I/O, bit 4 watch the write side |
| src_addr_i | input | 16 | Programmed source address |
| dst_addr_i | input | 16 | Programmed destination address |
| len_i | input | 16 | Programmed byte count (0 = 65536) |
| presc_i | input | 16 | Ticks per timed byte (0 = 65536) |
| probe_addr_i | input | 16 | Watch address |
| tick_fast_i | input | 1 | Pacing tick for memory-to-memory transfers |
| tick_slow_i | input | 1 | Pacing tick for transfers with an I/O side |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant from the arbiter |
| addr_o | output | 16 | Bus address during read or write |
| rdata_i | input | 8 | Read data from the bus |
| wdata_o | output | 8 | Write data to the bus |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| cpu_hold_o | output | 1 | Holds the CPU during a burst |
| busy_o | output | 1 | A transfer is active |
| probe_hit_o | output | 1 | One-cycle watch-address match |

## Verification
The bench compares every output pin against a reference model in every cycle. A corrupted working address therefore shows on `addr_o` at the very next strobe. A wrong remaining count shows on `busy_o`, either too early or too late, in the cycle after the last byte. A fault in the pacer appears within one prescaler interval as a shifted write strobe. A wrong probe match shows on `probe_hit_o` one cycle after the access concerned.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_REQ,
        ST_RD,
        ST_WR
    } seq_state_e;

    localparam logic [1:0] MODE_OFF   = 2'b00;
    localparam logic [1:0] MODE_BURST = 2'b01;
    localparam logic [1:0] MODE_ONCE  = 2'b10;
    localparam logic [1:0] MODE_LOOP  = 2'b11;

    localparam int CTL_DST_IO = 2;
    localparam int CTL_SRC_IO = 3;
    localparam int CTL_PRB_WR = 4;

endpackage

// File: rtl/dma_pacer.sv
module dma_pacer #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          use_slow,
    input  logic          tick_fast,
    input  logic          tick_slow,
    input  logic          take,
    input  logic [PW-1:0] period,
    output logic          pend
);

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          pend;
    } pacer_t;

    pacer_t pc_d, pc_q;
    logic   tick;
    logic   expire;

    always_comb begin
        pc_d   = pc_q;
        tick   = use_slow ? tick_slow : tick_fast;
        expire = tick && (pc_q.cnt == period - PW'(1));
        if (!run) begin
            pc_d = '0;
        end else begin
            if (tick) pc_d.cnt = expire ? '0 : pc_q.cnt + PW'(1);
            pc_d.pend = expire || (pc_q.pend && !take);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pend = pc_q.pend;

endmodule

// File: rtl/dma_probe.sv
module dma_probe #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_fire,
    input  logic          wr_fire,
    input  logic          on_wr,
    input  logic [AW-1:0] rd_addr,
    input  logic [AW-1:0] wr_addr,
    input  logic [AW-1:0] watch,
    output logic          hit
);

    logic hit_d, hit_q;

    always_comb begin
        if (on_wr) hit_d = wr_fire && (wr_addr == watch);
        else       hit_d = rd_fire && (rd_addr == watch);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit_d;
    end

    assign hit = hit_q;

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int LW = 16,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    ctrl_i,
    input  logic [AW-1:0] src_addr_i,
    input  logic [AW-1:0] dst_addr_i,
    input  logic [LW-1:0] len_i,
    input  logic [PW-1:0] presc_i,
    input  logic [AW-1:0] probe_addr_i,
    input  logic          tick_fast_i,
    input  logic          tick_slow_i,
    output logic          bus_req_o,
    input  logic          bus_gnt_i,
    output logic [AW-1:0] addr_o,
    input  logic [DW-1:0] rdata_i,
    output logic [DW-1:0] wdata_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic          io_rd_o,
    output logic          io_wr_o,
    output logic          cpu_hold_o,
    output logic          busy_o,
    output logic          probe_hit_o
);

    localparam int CW = LW + 1;

    typedef struct packed {
        seq_state_e    st;
        logic [1:0]    mode;
        logic          sio;
        logic          dio;
        logic          pwr;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] rem;
        logic [DW-1:0] data;
        logic [1:0]    prev;
    } core_t;

    core_t         c_d, c_q;
    logic          take;
    logic          pend;
    logic          start;
    logic [CW-1:0] full_len;
    logic [1:0]    mode_in;

    assign mode_in  = ctrl_i[1:0];
    assign full_len = (len_i == '0) ? (CW'(1) << LW) : CW'(len_i);
    assign start    = (c_q.st == ST_IDLE) && (mode_in != MODE_OFF) && (c_q.prev == MODE_OFF);

    always_comb begin
        c_d      = c_q;
        c_d.prev = mode_in;
        take     = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.mode = mode_in;
                    c_d.sio  = ctrl_i[CTL_SRC_IO];
                    c_d.dio  = ctrl_i[CTL_DST_IO];
                    c_d.pwr  = ctrl_i[CTL_PRB_WR];
                    c_d.src  = src_addr_i;
                    c_d.dst  = dst_addr_i;
                    c_d.rem  = full_len;
                    c_d.st   = (mode_in == MODE_BURST) ? ST_REQ : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (pend) begin
                    take   = 1'b1;
                    c_d.st = ST_REQ;
                end
            end
            ST_REQ: begin
                if (bus_gnt_i) c_d.st = ST_RD;
            end
            ST_RD: begin
                c_d.data = rdata_i;
                c_d.st   = ST_WR;
            end
            ST_WR: begin
                c_d.rem = c_q.rem - CW'(1);
                if (!c_q.sio) c_d.src = c_q.src + AW'(1);
                if (!c_q.dio) c_d.dst = c_q.dst + AW'(1);
                if (c_q.rem == CW'(1)) begin
                    if (c_q.mode == MODE_LOOP) begin
                        c_d.src = src_addr_i;
                        c_d.dst = dst_addr_i;
                        c_d.rem = full_len;
                        c_d.st  = ST_WAIT;
                    end else begin
                        c_d.st  = ST_IDLE;
                    end
                end else begin
                    c_d.st = (c_q.mode == MODE_BURST) ? ST_REQ : ST_WAIT;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
        if (c_q.st != ST_IDLE && mode_in == MODE_OFF) c_d.st = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q    <= c_d;
        end
    end

    dma_pacer #(.PW(PW)) i_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       ((c_q.st != ST_IDLE) && c_q.mode[1]),
        .use_slow  (c_q.sio || c_q.dio),
        .tick_fast (tick_fast_i),
        .tick_slow (tick_slow_i),
        .take      (take),
        .period    (presc_i),
        .pend      (pend)
    );

    dma_probe #(.AW(AW)) i_probe (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_fire (c_q.st == ST_RD),
        .wr_fire (c_q.st == ST_WR),
        .on_wr   (c_q.pwr),
        .rd_addr (c_q.src),
        .wr_addr (c_q.dst),
        .watch   (probe_addr_i),
        .hit     (probe_hit_o)
    );

    assign busy_o     = (c_q.st != ST_IDLE);
    assign bus_req_o  = (c_q.st == ST_REQ) || (c_q.st == ST_RD) || (c_q.st == ST_WR);
    assign cpu_hold_o = busy_o && (c_q.mode == MODE_BURST);
    assign mem_rd_o   = (c_q.st == ST_RD) && !c_q.sio;
    assign io_rd_o    = (c_q.st == ST_RD) &&  c_q.sio;
    assign mem_wr_o   = (c_q.st == ST_WR) && !c_q.dio;
    assign io_wr_o    = (c_q.st == ST_WR) &&  c_q.dio;
    assign addr_o     = (c_q.st == ST_RD) ? c_q.src : ((c_q.st == ST_WR) ? c_q.dst : '0);
    assign wdata_o    = (c_q.st == ST_WR) ? c_q.data : '0;

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctrl_i,
    input logic       bus_req_o,
    input logic       mem_rd_o,
    input logic       mem_wr_o,
    input logic       io_rd_o,
    input logic       io_wr_o,
    input logic       cpu_hold_o,
    input logic       busy_o,
    input logic       probe_hit_o
);

    logic any_rd, any_wr;
    assign any_rd = mem_rd_o || io_rd_o;
    assign any_wr = mem_wr_o || io_wr_o;

    a_r1_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        any_rd |=> (any_wr || !busy_o));

    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_o, mem_wr_o, io_rd_o, io_wr_o}));

    a_r6_strobe_under_request: assert property (@(posedge clk) disable iff (!rst_n)
        (any_rd || any_wr) |-> bus_req_o);

    a_r4_hold_keeps_request: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hold_o |-> (busy_o && bus_req_o));

    a_r9_stop_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ctrl_i[1:0] == 2'b00) |=> !busy_o);

    a_r10_hit_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        probe_hit_o |-> $past(any_rd || any_wr));

endmodule

bind dma_seq dma_seq_chk i_dma_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_i      (ctrl_i),
    .bus_req_o   (bus_req_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .io_rd_o     (io_rd_o),
    .io_wr_o     (io_wr_o),
    .cpu_hold_o  (cpu_hold_o),
    .busy_o      (busy_o),
    .probe_hit_o (probe_hit_o)
);

// File: tb/test_dma_seq.sv
`timescale 1ns/1ps
module test_dma_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ctrl = 8'h00;
    logic [15:0] src = 16'h0, dst = 16'h0, len = 16'h1, presc = 16'h1, probe = 16'hFFFF;
    logic        tick_fast = 1'b0, tick_slow = 1'b0, gnt = 1'b0, gnt_block = 1'b0;
    logic [7:0]  rdata;
    logic        bus_req, mem_rd, mem_wr, io_rd, io_wr, hold, busy, hit;
    logic [15:0] addr;
    logic [7:0]  wdata;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] pat(input logic [15:0] a, input logic io);
        return a[7:0] ^ a[15:8] ^ (io ? 8'hC3 : 8'h5A);
    endfunction

    assign rdata = (mem_rd || io_rd) ? pat(addr, io_rd) : 8'h00;

    dma_seq i_dma_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .src_addr_i(src), .dst_addr_i(dst),
        .len_i(len), .presc_i(presc), .probe_addr_i(probe), .tick_fast_i(tick_fast),
        .tick_slow_i(tick_slow), .bus_req_o(bus_req), .bus_gnt_i(gnt), .addr_o(addr),
        .rdata_i(rdata), .wdata_o(wdata), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
        .io_rd_o(io_rd), .io_wr_o(io_wr), .cpu_hold_o(hold), .busy_o(busy),
        .probe_hit_o(hit)
    );

    // tick and grant environment
    always @(negedge clk) begin
        cyc++;
        tick_fast = (cyc % 2 == 0);
        tick_slow = (cyc % 16 == 0);
        gnt       = bus_req && !gnt_block;
    end

    // behavioural reference: phase 0 idle, 1 pacing wait, 2 request, 3 read, 4 write
    int m_ph = 0, m_mode = 0, m_prev = 0, m_rem = 0, m_pcnt = 0;
    bit m_sio = 0, m_dio = 0, m_pwr = 0, m_pend = 0, m_hit = 0;
    int m_src = 0, m_dst = 0, m_data = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_mode = 0; m_prev = 0; m_rem = 0; m_pcnt = 0;
            m_pend = 0; m_hit = 0; m_src = 0; m_dst = 0; m_data = 0;
            m_sio = 0; m_dio = 0; m_pwr = 0;
        end else begin
            int  mode_now, ph_n, period;
            bit  tk, exp, take, run;
            mode_now = int'(ctrl[1:0]);
            run      = (m_ph != 0) && (m_mode >= 2);
            take     = (m_ph == 1) && m_pend;
            tk       = (m_sio || m_dio) ? tick_slow : tick_fast;
            period   = (presc == 0) ? 65536 : int'(presc);
            m_hit    = (m_ph == 3 && !m_pwr && m_src == int'(probe)) ||
                       (m_ph == 4 &&  m_pwr && m_dst == int'(probe));
            if (!run) begin
                m_pcnt = 0; m_pend = 0;
            end else begin
                exp = tk && (m_pcnt == period - 1);
                if (tk) m_pcnt = exp ? 0 : m_pcnt + 1;
                m_pend = exp || (m_pend && !take);
            end
            ph_n = m_ph;
            case (m_ph)
                0: if (mode_now != 0 && m_prev == 0) begin
                       m_mode = mode_now; m_sio = ctrl[3]; m_dio = ctrl[2]; m_pwr = ctrl[4];
                       m_src = int'(src); m_dst = int'(dst);
                       m_rem = (len == 0) ? 65536 : int'(len);
                       ph_n = (mode_now == 1) ? 2 : 1;
                   end
                1: if (take) ph_n = 2;
                2: if (gnt) ph_n = 3;
                3: begin m_data = int'(pat(m_src[15:0], m_sio)); ph_n = 4; end
                4: begin
                       if (!m_sio) m_src = (m_src + 1) % 65536;
                       if (!m_dio) m_dst = (m_dst + 1) % 65536;
                       m_rem = m_rem - 1;
                       if (m_rem == 0) begin
                           if (m_mode == 3) begin
                               m_src = int'(src); m_dst = int'(dst);
                               m_rem = (len == 0) ? 65536 : int'(len);
                               ph_n = 1;
                           end else ph_n = 0;
                       end else ph_n = (m_mode == 1) ? 2 : 1;
                   end
                default: ph_n = 0;
            endcase
            if (m_ph != 0 && mode_now == 0) ph_n = 0;
            m_ph   = ph_n;
            m_prev = mode_now;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
        end
    endtask

    // per-cycle comparison of every output
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int e_addr, e_wd;
            e_addr = (m_ph == 3) ? m_src : ((m_ph == 4) ? m_dst : 0);
            e_wd   = (m_ph == 4) ? m_data : 0;
            chk(busy == (m_ph != 0), "R11", "busy", int'(busy), int'(m_ph != 0));
            chk(bus_req == (m_ph >= 2), "R6", "bus_req", int'(bus_req), int'(m_ph >= 2));
            chk(hold == (m_ph != 0 && m_mode == 1), "R4", "cpu_hold", int'(hold), int'(m_ph != 0 && m_mode == 1));
            chk({mem_rd, io_rd, mem_wr, io_wr} == {m_ph == 3 && !m_sio, m_ph == 3 && m_sio,
                                                  m_ph == 4 && !m_dio, m_ph == 4 && m_dio},
                "R2", "strobes", int'({mem_rd, io_rd, mem_wr, io_wr}),
                int'({m_ph == 3 && !m_sio, m_ph == 3 && m_sio, m_ph == 4 && !m_dio, m_ph == 4 && m_dio}));
            chk(int'(addr) == e_addr, "R3", "addr", int'(addr), e_addr);
            chk(int'(wdata) == e_wd, "R1", "wdata", int'(wdata), e_wd);
            chk(hit == m_hit, "R10", "probe_hit", int'(hit), int'(m_hit));
        end
    end

    task automatic summary();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cyc > 150000 && !done) begin
            miscompares++;
            $display("FAIL R11 watchdog expired: actual cycle %0d expected below 150000", cyc);
            summary();
        end
    end

    task automatic setup(input logic [7:0] c, input logic [15:0] s, input logic [15:0] d,
                         input logic [15:0] l, input logic [15:0] p, input logic [15:0] pr);
        src = s; dst = d; len = l; presc = p; probe = pr;
        @(negedge clk);
        ctrl = c;
    endtask

    task automatic stop_all();
        ctrl = 8'h00;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int writes, hits, loose, io_rd_n, last_w, bad_gap, bad_addr, reads_start;
        repeat (3) @(negedge clk);
        chk(!busy && !bus_req && !hold && !hit && !mem_rd && !mem_wr && !io_rd && !io_wr,
            "R11", "reset outputs", int'({busy, bus_req, hold, hit}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // burst memory to memory, watch a read address
        setup(8'h01, 16'h1000, 16'h2000, 16'd5, 16'd1, 16'h1002);
        writes = 0; hits = 0; loose = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (mem_wr) writes++;
            if (hit) hits++;
            if (busy && !hold) loose++;
            if (!busy && i > 2) break;
        end
        chk(writes == 5, "R5", "burst byte count", writes, 5);
        chk(hits == 1, "R10", "read-side hits", hits, 1);
        chk(loose == 0, "R4", "cycles busy without hold", loose, 0);
        repeat (10) @(negedge clk);
        chk(!busy, "R8", "one-shot burst stays idle while mode held", int'(busy), 0);
        stop_all();

        // burst I/O to memory, watch a write address, grant withheld at first
        gnt_block = 1'b1;
        setup(8'h19, 16'h00FE, 16'h3000, 16'd3, 16'd1, 16'h3002);
        writes = 0; hits = 0; io_rd_n = 0; bad_addr = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (i == 5) gnt_block = 1'b0;
            if (i < 5 && (mem_rd || io_rd || mem_wr || io_wr)) bad_addr++;
            if (io_rd) begin io_rd_n++; if (addr != 16'h00FE) bad_addr++; end
            if (mem_wr) writes++;
            if (hit) hits++;
            if (!busy && i > 6) break;
        end
        chk(io_rd_n == 3, "R2", "I/O reads", io_rd_n, 3);
        chk(writes == 3, "R2", "memory writes", writes, 3);
        chk(bad_addr == 0, "R3", "I/O address or early strobe", bad_addr, 0);
        chk(hits == 1, "R10", "write-side hits", hits, 1);
        stop_all();

        // timed one-shot memory to memory, presc 3 on fast tick (every 2 cycles)
        setup(8'h02, 16'h0100, 16'h0200, 16'd4, 16'd3, 16'hFFFF);
        writes = 0; last_w = -1; bad_gap = 0; loose = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (busy && !bus_req) loose++;
            if (mem_wr) begin
                if (last_w >= 0 && i - last_w != 6) bad_gap++;
                last_w = i; writes++;
            end
            if (!busy && i > 2) break;
        end
        chk(writes == 4, "R6", "timed byte count", writes, 4);
        chk(bad_gap == 0, "R7", "fast-tick spacing of 6 cycles", bad_gap, 0);
        chk(loose > 0, "R6", "bus released between bytes", loose, 1);
        stop_all();

        // timed one-shot memory to I/O, presc 2 on slow tick (every 16 cycles)
        setup(8'h06, 16'h0400, 16'h00DF, 16'd3, 16'd2, 16'hFFFF);
        writes = 0; last_w = -1; bad_gap = 0; bad_addr = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (io_wr) begin
                if (last_w >= 0 && i - last_w != 32) bad_gap++;
                if (addr != 16'h00DF) bad_addr++;
                last_w = i; writes++;
            end
            if (!busy && i > 2) break;
        end
        chk(writes == 3, "R6", "timed I/O byte count", writes, 3);
        chk(bad_gap == 0, "R7", "slow-tick spacing of 32 cycles", bad_gap, 0);
        chk(bad_addr == 0, "R3", "constant I/O destination", bad_addr, 0);
        stop_all();

        // timed repeating, length 2: source restarts by itself
        setup(8'h03, 16'h0040, 16'h0500, 16'd2, 16'd1, 16'hFFFF);
        reads_start = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (mem_rd && addr == 16'h0040) reads_start++;
        end
        chk(reads_start >= 3, "R8", "reloaded start reads", reads_start, 3);
        chk(busy, "R8", "repeating mode still busy", int'(busy), 1);
        ctrl = 8'h00;
        @(negedge clk);
        chk(!busy, "R9", "stop drops busy next cycle", int'(busy), 0);
        repeat (2) @(negedge clk);

        // burst with length 0 runs past 256 bytes, then restart from the top
        setup(8'h01, 16'h8000, 16'hC000, 16'd0, 16'd1, 16'hFFFF);
        writes = 0;
        for (int i = 0; i < 900; i++) begin
            @(negedge clk);
            if (mem_wr) writes++;
        end
        chk(busy, "R5", "length 0 still running", int'(busy), 1);
        chk(writes > 256, "R5", "length 0 beyond 256 bytes", writes, 257);
        ctrl = 8'h00;
        @(negedge clk);
        ctrl = 8'h01;
        reads_start = -1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (mem_rd && reads_start < 0) reads_start = int'(addr);
        end
        chk(reads_start == 32'h8000, "R9", "restart from programmed source", reads_start, 32'h8000);
        stop_all();

        summary();
    end

endmodule